// File: doc/BRIEF.md
# Protection and Break Status Word

This block is the 32-bit status word of a memory protection and debug-support unit. It keeps the details of the last bus operand captured by the bus monitor, which are the operand size and the kind of access. It also holds two sticky flags. The violation flag is raised by a pulse from the permission checker. While it is set, it drives a trap request to the CPU, and only a software write of zero takes it down. The reset-seen flag is raised by either reset level. Software can read it but cannot write it, and it clears itself once the word has been read.

Software reaches the word through a single-word register bus. Reads and writes are qualified by per-byte lane enables. `rdata` presents the current word continuously, so a read returns the value held before the clock edge that performs any clear. Two reset levels exist. `init_rst_n` is an asynchronous full initialization. `op_rst` is a synchronous operation-level reset pulse. Each flag is tracked by a two-state machine:
- Violation tracker: PV_CLEAR and PV_RAISED. The transitions are *raise* (violation pulse), *ack* (a write of zero) and *op-reset*.
- Reset-seen tracker: RF_QUIET and RF_SEEN. The transitions are *mark* (either reset) and *consume* (a read).

Field layout of the word:
- Bits 9:8: size. 00 = 8-bit, 01 = 16-bit, 10 = 32-bit, 11 = reserved.
- Bits 7:6: access type. 00 = read, 01 = read-modify-write, 10 = write, 11 = none.
- Bit 5: violation.
- Bit 4: reset-seen.
- All other bits read as zero.

Top module: `prot_status_reg`

## Requirements
- R1: After `init_rst_n` is asserted the word reads 0x000000D0 and `trap_req` is 0. That value means size 00, access type 11, bit 5 = 0 and bit 4 = 1.
- R2: On a cycle with `cap_valid` high, bits 9:8 load `cap_size` and bits 7:6 load `cap_kind`. The size code 11 is stored unchanged. Without `cap_valid` both fields hold.
- R3: A `viol` pulse sets bit 5 from the next cycle on. `trap_req` equals bit 5 without any added delay.
- R4: Bit 5 clears only on a write (`sel`, `wr_en`) with `be[0]`=1 and `wdata[5]`=0. A write with `wdata[5]`=1 has no effect on bit 5, and neither does a write with `be[0]`=0.
- R5: When `viol` and a clearing write occur in the same cycle, bit 5 ends up 1.
- R6: An `op_rst` pulse sets bit 4, clears bit 5, and returns bits 9:8 to 00 and bits 7:6 to 11.
- R7: Bit 4 clears after any read (`sel`, `rd_en`) in which any `be` bit is set, whichever lane that is. Writes never change bit 4.
- R8: A read-modify-write, meaning `rd_en` and `wr_en` high in the same cycle, clears bit 4 the same way a read does, and the write part still acts on bit 5.
- R9: When `op_rst` and a clearing read occur in the same cycle, bit 4 ends up 1.
- R10: Bits 31:10 and 3:0 always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| init_rst_n | input | 1 | Asynchronous full initialization reset, active low |
| op_rst | input | 1 | Synchronous operation-level reset pulse |
| sel | input | 1 | Register selected by the bus |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| be | input | 4 | Byte lane enables |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Current status word |
| cap_valid | input | 1 | Capture strobe from the bus monitor |
| cap_size | input | 2 | Captured operand size code |
| cap_kind | input | 2 | Captured access type code |
| viol | input | 1 | Protection violation pulse |
| trap_req | output | 1 | Trap request to the CPU |

## Verification
The checker watches these rules on every cycle:
- A violation pulse sets bit 5, and the bit stays set until a valid clear.
- A zero-write acknowledge takes bit 5 down.
- Either reset marks bit 4.
- A read consumes bit 4, and nothing else sets it.
- The capture fields stay stable without a strobe.
- The unused bits stay zero.

Other behaviours depend on particular data patterns, and only the bench's scenarios can show them. These are the exact field encodings after a capture, the ignored lane-1..3 or one-valued writes, the two same-cycle priority cases, and the read-modify-write combination.

// File: rtl/prot_status_pkg.sv
package prot_status_pkg;
    localparam int SIZE_LSB = 8;
    localparam int KIND_LSB = 6;
    localparam int VIOL_BIT = 5;
    localparam int RSEEN_BIT = 4;
    localparam int CODE_W = 2;

    localparam logic [CODE_W-1:0] SIZE_INIT = 2'b00;
    localparam logic [CODE_W-1:0] KIND_NONE = 2'b11;

    typedef enum logic {
        PV_CLEAR  = 1'b0,
        PV_RAISED = 1'b1
    } pv_state_t;

    typedef enum logic {
        RF_QUIET = 1'b0,
        RF_SEEN  = 1'b1
    } rf_state_t;
endpackage

// File: rtl/prot_capture.sv
module prot_capture
    import prot_status_pkg::*;
(
    input  logic              clk,
    input  logic              init_rst_n,
    input  logic              op_rst,
    input  logic              cap_valid,
    input  logic [CODE_W-1:0] cap_size,
    input  logic [CODE_W-1:0] cap_kind,
    output logic [CODE_W-1:0] size_q,
    output logic [CODE_W-1:0] kind_q
);
    always_ff @(posedge clk or negedge init_rst_n) begin
        if (!init_rst_n) begin
            size_q <= SIZE_INIT;
            kind_q <= KIND_NONE;
        end else if (op_rst) begin
            size_q <= SIZE_INIT;
            kind_q <= KIND_NONE;
        end else if (cap_valid) begin
            size_q <= cap_size;
            kind_q <= cap_kind;
        end
    end
endmodule

// File: rtl/prot_viol_fsm.sv
module prot_viol_fsm
    import prot_status_pkg::*;
(
    input  logic clk,
    input  logic init_rst_n,
    input  logic op_rst,
    input  logic viol,
    input  logic ack,
    output logic raised
);
    pv_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PV_CLEAR:  if (viol) state_d = PV_RAISED;
            PV_RAISED: if (!viol && ack) state_d = PV_CLEAR;
            default:   state_d = PV_CLEAR;
        endcase
        if (op_rst) state_d = PV_CLEAR;
    end

    always_ff @(posedge clk or negedge init_rst_n) begin
        if (!init_rst_n) state_q <= PV_CLEAR;
        else             state_q <= state_d;
    end

    always_comb begin
        raised = (state_q == PV_RAISED);
    end
endmodule

// File: rtl/prot_rseen_fsm.sv
module prot_rseen_fsm
    import prot_status_pkg::*;
(
    input  logic clk,
    input  logic init_rst_n,
    input  logic op_rst,
    input  logic consume,
    output logic seen
);
    rf_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RF_QUIET: if (op_rst) state_d = RF_SEEN;
            RF_SEEN:  if (!op_rst && consume) state_d = RF_QUIET;
            default:  state_d = RF_SEEN;
        endcase
    end

    always_ff @(posedge clk or negedge init_rst_n) begin
        if (!init_rst_n) state_q <= RF_SEEN;
        else             state_q <= state_d;
    end

    always_comb begin
        seen = (state_q == RF_SEEN);
    end
endmodule

// File: rtl/prot_status_reg.sv
module prot_status_reg
    import prot_status_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BE_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              init_rst_n,
    input  logic              op_rst,
    input  logic              sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              cap_valid,
    input  logic [1:0]        cap_size,
    input  logic [1:0]        cap_kind,
    input  logic              viol,
    output logic              trap_req
);
    logic              rd_hit;
    logic              ack;
    logic              viol_q;
    logic              seen_q;
    logic [CODE_W-1:0] size_q;
    logic [CODE_W-1:0] kind_q;
    logic              unused_wdata;

    assign rd_hit       = sel && rd_en && (|be);
    assign ack          = sel && wr_en && be[VIOL_BIT/8] && !wdata[VIOL_BIT];
    assign unused_wdata = ^{wdata[DATA_W-1:VIOL_BIT+1], wdata[VIOL_BIT-1:0]};

    prot_capture u_cap (
        .clk        (clk),
        .init_rst_n (init_rst_n),
        .op_rst     (op_rst),
        .cap_valid  (cap_valid),
        .cap_size   (cap_size),
        .cap_kind   (cap_kind),
        .size_q     (size_q),
        .kind_q     (kind_q)
    );

    prot_viol_fsm u_viol (
        .clk        (clk),
        .init_rst_n (init_rst_n),
        .op_rst     (op_rst),
        .viol       (viol),
        .ack        (ack),
        .raised     (viol_q)
    );

    prot_rseen_fsm u_rseen (
        .clk        (clk),
        .init_rst_n (init_rst_n),
        .op_rst     (op_rst),
        .consume    (rd_hit),
        .seen       (seen_q)
    );

    always_comb begin
        rdata = '0;
        rdata[SIZE_LSB +: CODE_W] = size_q;
        rdata[KIND_LSB +: CODE_W] = kind_q;
        rdata[VIOL_BIT]           = viol_q;
        rdata[RSEEN_BIT]          = seen_q;
        trap_req                  = viol_q;
    end
endmodule

// File: rtl/prot_status_chk.sv
module prot_status_chk (
    input logic        clk,
    input logic        init_rst_n,
    input logic        op_rst,
    input logic        sel,
    input logic        rd_en,
    input logic        wr_en,
    input logic [3:0]  be,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        cap_valid,
    input logic        viol,
    input logic        trap_req
);
    logic rd_hit_c;
    logic ack_c;
    assign rd_hit_c = sel && rd_en && (|be);
    assign ack_c    = sel && wr_en && be[0] && !wdata[5];

    assert_viol_sets_R3: assert property (@(posedge clk) disable iff (!init_rst_n)
        (viol && !op_rst) |=> trap_req);

    assert_viol_sticky_R4: assert property (@(posedge clk) disable iff (!init_rst_n)
        (trap_req && !ack_c && !op_rst) |=> trap_req);

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!init_rst_n)
        (ack_c && !viol) |=> !trap_req);

    assert_op_marks_R6: assert property (@(posedge clk) disable iff (!init_rst_n)
        op_rst |=> (rdata[4] && !trap_req));

    assert_read_consumes_R7: assert property (@(posedge clk) disable iff (!init_rst_n)
        (rd_hit_c && !op_rst) |=> !rdata[4]);

    assert_no_write_set_R7: assert property (@(posedge clk) disable iff (!init_rst_n)
        (!rdata[4] && !op_rst) |=> !rdata[4]);

    assert_capture_hold_R2: assert property (@(posedge clk) disable iff (!init_rst_n)
        (!cap_valid && !op_rst) |=> $stable(rdata[9:6]));

    assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!init_rst_n)
        (rdata[31:10] == 22'd0) && (rdata[3:0] == 4'd0));
endmodule

bind prot_status_reg prot_status_chk u_chk (
    .clk        (clk),
    .init_rst_n (init_rst_n),
    .op_rst     (op_rst),
    .sel        (sel),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .be         (be),
    .wdata      (wdata),
    .rdata      (rdata),
    .cap_valid  (cap_valid),
    .viol       (viol),
    .trap_req   (trap_req)
);

// File: tb/tb_prot_status_reg.sv
`timescale 1ns/1ps
module tb_prot_status_reg;
    logic        clk = 1'b0;
    logic        init_rst_n = 1'b0;
    logic        op_rst = 1'b0;
    logic        sel = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  be = 4'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        cap_valid = 1'b0;
    logic [1:0]  cap_size = 2'd0;
    logic [1:0]  cap_kind = 2'd0;
    logic        viol = 1'b0;
    logic        trap_req;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    prot_status_reg dut (
        .clk(clk), .init_rst_n(init_rst_n), .op_rst(op_rst), .sel(sel),
        .rd_en(rd_en), .wr_en(wr_en), .be(be), .wdata(wdata), .rdata(rdata),
        .cap_valid(cap_valid), .cap_size(cap_size), .cap_kind(cap_kind),
        .viol(viol), .trap_req(trap_req)
    );

    task automatic check(input logic [31:0] exp_w, input logic exp_t, input string req);
        n_checks++;
        if (rdata !== exp_w || trap_req !== exp_t) begin
            n_fail++;
            $display("FAIL %s: rdata=%h trap=%b expected rdata=%h trap=%b",
                     req, rdata, trap_req, exp_w, exp_t);
        end
    endtask

    task automatic idle();
        op_rst = 0; sel = 0; rd_en = 0; wr_en = 0; be = 0; wdata = 0;
        cap_valid = 0; viol = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic bus(input logic rd, input logic wr, input logic [3:0] lanes,
                       input logic [31:0] d);
        sel = 1; rd_en = rd; wr_en = wr; be = lanes; wdata = d;
        tick();
    endtask

    task automatic t_reset_R1();
        check(32'h0000_00D0, 1'b0, "R1 init value");
    endtask

    task automatic t_read_and_write_R7();
        bus(1, 0, 4'b1000, 0);
        check(32'h0000_00C0, 1'b0, "R7 read via lane 3 clears bit4");
        bus(0, 1, 4'b1111, 32'hFFFF_FFFF);
        check(32'h0000_00C0, 1'b0, "R7/R10/R4 all-ones write ignored");
    endtask

    task automatic t_capture_R2();
        cap_valid = 1; cap_size = 2'b01; cap_kind = 2'b00; tick();
        check(32'h0000_0100, 1'b0, "R2 capture 16-bit read");
        cap_size = 2'b10; cap_kind = 2'b10; tick();
        check(32'h0000_0100, 1'b0, "R2 hold without strobe");
        cap_valid = 1; cap_size = 2'b11; cap_kind = 2'b01; tick();
        check(32'h0000_0340, 1'b0, "R2 reserved size stored, rmw type");
    endtask

    task automatic t_violation_R3_R4();
        viol = 1; tick();
        check(32'h0000_0360, 1'b1, "R3 violation sets bit5 and trap");
        bus(0, 1, 4'b1110, 0);
        check(32'h0000_0360, 1'b1, "R4 zero write without lane0 ignored");
        bus(0, 1, 4'b0001, 32'h0000_0020);
        check(32'h0000_0360, 1'b1, "R4 writing one keeps bit5");
        bus(0, 1, 4'b0001, 0);
        check(32'h0000_0340, 1'b0, "R4 zero write clears bit5");
    endtask

    task automatic t_priority_R5();
        viol = 1; bus(0, 1, 4'b0001, 0);
        check(32'h0000_0360, 1'b1, "R5 violation beats clear");
        bus(0, 1, 4'b0001, 0);
        check(32'h0000_0340, 1'b0, "R5 later clear");
    endtask

    task automatic t_op_reset_R6_R9();
        viol = 1; tick();
        check(32'h0000_0360, 1'b1, "R6 setup violation");
        op_rst = 1; tick();
        check(32'h0000_00D0, 1'b0, "R6 op reset restores fields, sets bit4");
        op_rst = 1; bus(1, 0, 4'b0001, 0);
        check(32'h0000_00D0, 1'b0, "R9 op reset beats read");
        bus(1, 0, 4'b0100, 0);
        check(32'h0000_00C0, 1'b0, "R7 read via lane 2 clears bit4");
        bus(1, 0, 4'b0000, 0);
        op_rst = 1; tick();
        bus(1, 0, 4'b0000, 0);
        check(32'h0000_00D0, 1'b0, "R7 read with no lanes keeps bit4");
    endtask

    task automatic t_rmw_R8();
        viol = 1; tick();
        check(32'h0000_00F0, 1'b1, "R8 setup both flags");
        bus(1, 1, 4'b0001, 0);
        check(32'h0000_00C0, 1'b0, "R8 rmw clears bit4 and bit5");
    endtask

    initial begin
        fork
            begin
                idle();
                repeat (2) @(negedge clk);
                init_rst_n = 1;
                @(negedge clk);
                t_reset_R1();
                t_read_and_write_R7();
                t_capture_R2();
                t_violation_R3_R4();
                t_priority_R5();
                t_op_reset_R6_R9();
                t_rmw_R8();
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule